// File: doc/BRIEF.md
# Gated Acceptance-Mask Register Bank

This block holds one 32-bit acceptance mask for each receive buffer index, 64 entries by default. A CPU reaches the masks over a simple single-cycle register bus: address, read strobe, write strobe, write data, read data and an error flag. A second, independent read port lets the frame filter engine fetch the mask it needs for the current comparison. Mask bits are stored exactly as written; using them to filter frames happens outside this block.

The storage is RAM-style and is not touched by reset, so software loads every entry before reception starts. CPU access depends on two control inputs. While the freeze-mode input is high and the feature-enable input is high, reads and writes behave normally. With feature-enable high but freeze-mode low, writes are silently dropped and reads return zero. With feature-enable low, every access returns an error and changes nothing, whatever the freeze state.

The filter port selects an entry in one of two ways. Receive-FIFO filter element e (0 to 7) uses entry e. A regular buffer m uses entry m, and regular buffers start at index 8. The filter port ignores the freeze and enable gating.

Top module: `mask_bank_regs`

## Requirements
- R1: A write strobe with `feat_en`=1 and `frz_mode`=1 stores `cpu_wdata` at entry `cpu_addr`. A later permitted read of that entry returns the stored value.
- R2: A write strobe with `feat_en`=1 and `frz_mode`=0 leaves storage unchanged and raises no error.
- R3: A read strobe with `feat_en`=1 and `frz_mode`=0 gives `cpu_rdata`=0 and `cpu_err`=0 in the following cycle.
- R4: A read or write strobe with `feat_en`=0 gives `cpu_err`=1 in the following cycle, whatever `frz_mode` is. That read returns 0, and that write does not modify storage. `cpu_err` is 0 in every cycle that does not follow such a strobe.
- R5: Read data appears one clock after a permitted read strobe (read-first if the same entry was written in that cycle). `cpu_rdata` is 0 in any cycle that does not follow a permitted read.
- R6: Reset leaves every stored mask unchanged.
- R7: With `flt_fifo`=1, `flt_mask` in the next cycle equals entry `flt_elem` and `flt_ok`=1, in any freeze or enable state.
- R8: With `flt_fifo`=0, a buffer index `flt_mb` >= 8 gives `flt_mask` = entry `flt_mb` and `flt_ok`=1 in the next cycle. An index below 8 gives `flt_mask`=0 and `flt_ok`=0.
- R9: During and right after a synchronous reset, `cpu_err`, `cpu_rdata`, `flt_mask` and `flt_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; storage is not cleared |
| frz_mode | input | 1 | Freeze-mode flag; CPU access to contents is open only while high |
| feat_en | input | 1 | Feature enable; any CPU access while low is an error |
| cpu_addr | input | 6 | Entry index for CPU access |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| cpu_err | output | 1 | Access error, the cycle after a faulting strobe |
| flt_fifo | input | 1 | Filter lookup selects a receive-FIFO filter element when high |
| flt_elem | input | 3 | FIFO filter element number |
| flt_mb | input | 6 | Regular buffer number |
| flt_mask | output | 32 | Mask for the selected lookup, one cycle later |
| flt_ok | output | 1 | Lookup mapped to a valid entry |

## Verification
The bench first checks that a disabled write, even in freeze mode, leaves the entry untouched. A design that let the freeze gate take precedence over the error would corrupt the mask. It also checks that a write outside freeze leaves no trace when read back later in freeze. It applies reset between loading and reading, because storage cleared by reset would return zeros. It sweeps regular buffer numbers below 8 to catch a mapping that wrongly aliases them onto the FIFO filter entries. It also runs filter lookups outside freeze, where a port wrongly tied to the CPU gating would return zero.

// File: rtl/mask_bank_pkg.sv
package mask_bank_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_OPEN  = 2'd1,
    ACC_MUTED = 2'd2,
    ACC_FAULT = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mask_bank_gate.sv
module mask_bank_gate
  import mask_bank_pkg::*;
(
  input  logic rd,
  input  logic wr,
  input  logic frz,
  input  logic en,
  output logic fault,
  output logic wr_commit,
  output logic rd_pass
);
  acc_kind_e kind;

  // Disabled feature outranks the freeze gate.
  always_comb begin
    if (!(rd || wr))   kind = ACC_IDLE;
    else if (!en)      kind = ACC_FAULT;
    else if (!frz)     kind = ACC_MUTED;
    else               kind = ACC_OPEN;
  end

  assign fault     = (kind == ACC_FAULT);
  assign wr_commit = (kind == ACC_OPEN) && wr;
  assign rd_pass   = (kind == ACC_OPEN) && rd;
endmodule

// File: rtl/mask_bank_mem.sv
module mask_bank_mem #(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_q,
  input  logic [AW-1:0]    b_addr,
  output logic [WIDTH-1:0] b_q
);
  logic [WIDTH-1:0] store [DEPTH];

  // No reset on purpose: contents survive reset.
  always_ff @(posedge clk) begin
    if (we) store[a_addr] <= a_wdata;
    a_q <= store[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= store[b_addr];
  end
endmodule

// File: rtl/mask_bank_fltmap.sv
module mask_bank_fltmap #(
  parameter int IDX_W      = 6,
  parameter int FIFO_ELEMS = 8,
  localparam int ELEM_W    = $clog2(FIFO_ELEMS)
) (
  input  logic              fifo_sel,
  input  logic [ELEM_W-1:0] elem,
  input  logic [IDX_W-1:0]  mb,
  output logic [IDX_W-1:0]  entry,
  output logic              ok
);
  always_comb begin
    if (fifo_sel) begin
      entry = IDX_W'(elem);
      ok    = 1'b1;
    end else begin
      entry = mb;
      ok    = (mb >= IDX_W'(FIFO_ELEMS));
    end
  end
endmodule

// File: rtl/mask_bank_regs.sv
module mask_bank_regs #(
  parameter int NUM_ENTRIES = 64,
  parameter int DATA_W      = 32,
  parameter int FIFO_ELEMS  = 8,
  localparam int ADDR_W     = $clog2(NUM_ENTRIES),
  localparam int ELEM_W     = $clog2(FIFO_ELEMS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frz_mode,
  input  logic              feat_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_err,
  input  logic              flt_fifo,
  input  logic [ELEM_W-1:0] flt_elem,
  input  logic [ADDR_W-1:0] flt_mb,
  output logic [DATA_W-1:0] flt_mask,
  output logic              flt_ok
);
  logic              fault, wr_commit, rd_pass;
  logic [ADDR_W-1:0] flt_entry;
  logic              map_ok;
  logic [DATA_W-1:0] a_q, b_q;
  logic              rd_pass_q, map_ok_q;

  mask_bank_gate u_gate (
    .rd(cpu_rd), .wr(cpu_wr), .frz(frz_mode), .en(feat_en),
    .fault(fault), .wr_commit(wr_commit), .rd_pass(rd_pass)
  );

  mask_bank_fltmap #(.IDX_W(ADDR_W), .FIFO_ELEMS(FIFO_ELEMS)) u_map (
    .fifo_sel(flt_fifo), .elem(flt_elem), .mb(flt_mb),
    .entry(flt_entry), .ok(map_ok)
  );

  mask_bank_mem #(.DEPTH(NUM_ENTRIES), .WIDTH(DATA_W)) u_mem (
    .clk(clk), .we(wr_commit),
    .a_addr(cpu_addr), .a_wdata(cpu_wdata), .a_q(a_q),
    .b_addr(flt_entry), .b_q(b_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pass_q <= 1'b0;
      cpu_err   <= 1'b0;
      map_ok_q  <= 1'b0;
    end else begin
      rd_pass_q <= rd_pass;
      cpu_err   <= fault;
      map_ok_q  <= map_ok;
    end
  end

  assign cpu_rdata = rd_pass_q ? a_q : '0;
  assign flt_mask  = map_ok_q  ? b_q : '0;
  assign flt_ok    = map_ok_q;
endmodule

// File: rtl/mask_bank_regs_chk.sv
module mask_bank_regs_chk #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int FIFO_ELEMS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frz_mode,
  input logic              feat_en,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              cpu_err,
  input logic              flt_fifo,
  input logic [ADDR_W-1:0] flt_mb,
  input logic [DATA_W-1:0] flt_mask,
  input logic              flt_ok
);
  a_r4_fault_flags: assert property (@(posedge clk) disable iff (rst)
    (!feat_en && (cpu_rd || cpu_wr)) |=> cpu_err);

  a_r4_err_only_on_fault: assert property (@(posedge clk) disable iff (rst)
    (feat_en || !(cpu_rd || cpu_wr)) |=> !cpu_err);

  a_r4_fault_read_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !feat_en) |=> (cpu_rdata == '0));

  a_r3_closed_read_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !frz_mode) |=> (cpu_rdata == '0));

  a_r5_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> (cpu_rdata == '0));

  a_r7_fifo_lookup_ok: assert property (@(posedge clk) disable iff (rst)
    flt_fifo |=> flt_ok);

  a_r8_low_mb_blank: assert property (@(posedge clk) disable iff (rst)
    (!flt_fifo && (flt_mb < ADDR_W'(FIFO_ELEMS))) |=> (!flt_ok && flt_mask == '0));
endmodule

bind mask_bank_regs mask_bank_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_ELEMS(FIFO_ELEMS)
) u_chk (.*);

// File: tb/mask_bank_regs_bench.sv
`timescale 1ns/1ps
module mask_bank_regs_bench;
  localparam int N  = 64;
  localparam int W  = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frz_mode = 1'b0, feat_en = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [W-1:0]  cpu_wdata = '0;
  logic [W-1:0]  cpu_rdata;
  logic          cpu_err;
  logic          flt_fifo = 1'b0;
  logic [2:0]    flt_elem = '0;
  logic [AW-1:0] flt_mb = '0;
  logic [W-1:0]  flt_mask;
  logic          flt_ok;

  always #2 clk = ~clk;

  mask_bank_regs u_mask_bank_regs (.*);

  int checks = 0, failures = 0;
  string cur_req = "R9";
  bit started = 0, loaded = 0, done = 0;

  logic [W-1:0] model [N];
  logic [W-1:0] exp_rdata = '0, exp_fmask = '0;
  logic         exp_err = 1'b0, exp_fok = 1'b0;

  function automatic logic [W-1:0] pat(int i, int salt);
    return (32'h9E3779B1 * (i + 1)) ^ (salt << 8) ^ i;
  endfunction

  // Reference model: reads first, then the write.
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      exp_err = 0; exp_rdata = '0; exp_fok = 0; exp_fmask = '0;
    end else begin
      int ent;
      bit okm;
      exp_err   = (cpu_rd || cpu_wr) && !feat_en;
      exp_rdata = (cpu_rd && feat_en && frz_mode) ? model[cpu_addr] : '0;
      if (flt_fifo) begin ent = flt_elem; okm = 1; end
      else begin ent = flt_mb; okm = (flt_mb >= 8); end
      exp_fok   = okm;
      exp_fmask = okm ? model[ent] : '0;
      if (cpu_wr && feat_en && frz_mode) model[cpu_addr] = cpu_wdata;
    end
  end

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(cur_req, "cpu_err", W'(cpu_err), W'(exp_err));
      chk(cur_req, "cpu_rdata", cpu_rdata, exp_rdata);
      if (loaded || rst) begin
        chk(cur_req, "flt_ok", W'(flt_ok), W'(exp_fok));
        chk(cur_req, "flt_mask", flt_mask, exp_fmask);
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic acc(bit rd, bit wr, int a, logic [W-1:0] d);
    @(posedge clk); #1;
    cpu_rd = rd; cpu_wr = wr; cpu_addr = AW'(a); cpu_wdata = d;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: explicit reset state check
    chk("R9", "reset err", W'(cpu_err), '0);
    chk("R9", "reset rdata", cpu_rdata, '0);
    chk("R9", "reset flt_ok", W'(flt_ok), '0);
    rst = 0;

    // R1: load every entry in freeze with enable
    cur_req = "R1"; frz_mode = 1; feat_en = 1;
    for (int i = 0; i < N; i++) acc(0, 1, i, pat(i, 1));
    idle();
    loaded = 1;
    for (int i = 0; i < N; i += 5) acc(1, 0, i, '0);
    // R5: read and write same entry together -> old data
    cur_req = "R5";
    acc(1, 1, 9, 32'hDEADBEEF);
    acc(1, 0, 9, '0);
    idle(); idle();
    acc(1, 0, 63, '0); idle(); acc(1, 0, 0, '0); idle();

    // R2: writes outside freeze are dropped
    cur_req = "R2"; frz_mode = 0;
    acc(0, 1, 3, 32'h11111111);
    acc(0, 1, 40, 32'h22222222);
    idle();
    frz_mode = 1;
    acc(1, 0, 3, '0); acc(1, 0, 40, '0); idle();

    // R3: reads outside freeze return zero
    cur_req = "R3"; frz_mode = 0;
    acc(1, 0, 7, '0); acc(1, 0, 41, '0); idle();

    // R4: disabled feature -> error, no write, zero read
    cur_req = "R4"; feat_en = 0; frz_mode = 1;
    acc(0, 1, 5, 32'hBADBAD00);
    acc(1, 0, 5, '0);
    idle();
    frz_mode = 0;
    acc(0, 1, 6, 32'hBADBAD01);
    acc(1, 0, 6, '0);
    idle();
    feat_en = 1; frz_mode = 1;
    acc(1, 0, 5, '0); acc(1, 0, 6, '0); idle();

    // R6: reset keeps contents
    cur_req = "R6";
    @(posedge clk); #1; rst = 1;
    repeat (2) @(posedge clk);
    #1; rst = 0;
    for (int i = 0; i < N; i += 7) acc(1, 0, i, '0);
    idle();

    // R7: FIFO filter lookups in every gate state
    cur_req = "R7";
    for (int g = 0; g < 4; g++) begin
      frz_mode = g[0]; feat_en = g[1];
      for (int e = 0; e < 8; e++) begin
        @(posedge clk); #1; flt_fifo = 1; flt_elem = 3'(e);
      end
    end

    // R8: regular buffer lookups, full sweep
    cur_req = "R8"; frz_mode = 0; feat_en = 1;
    for (int m = 0; m < N; m++) begin
      @(posedge clk); #1; flt_fifo = 0; flt_mb = AW'(m);
    end
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired in %s actual=running expected=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule